// File: doc/BRIEF.md
# DRAM Controller Register Stub

This block stands in for a DRAM controller while boot firmware brings the memory system up. It has three register windows of 4 KiB each: a common window, a controller window and a PHY window. Each window holds a parameterised number of 32-bit words. They are reached through one word bus that carries a window select, a byte address inside the window, an access size, a write enable and write data. Read data comes back one cycle after the address is presented.

The block trains nothing and models no timing. A write to the PHY initialisation word in the controller window completes the initialisation handshake on the spot: it raises the init-done flag and the controller-active flag in two other words of that window. A write to the control word of the common window is decoded into memory geometry: the row address width, the bank address width and the page size. The decoded geometry is handed to an external address-aliasing unit together with a one-cycle strobe.

Top module: `dram_reg_stub`

## Requirements
- R1: While `rst` is high at a clock edge, every word in all three windows becomes zero, `rd_data` becomes zero and `geo_valid` becomes low.
- R2: An accepted write stores the full 32-bit `bus_wdata` in the addressed word, and byte enables do not exist. The word index is `bus_addr[11:2]`. `rd_data` shows, one cycle after an accepted access, the value the addressed word held before that cycle's write.
- R3: An accepted write to byte offset 0x000 of the controller window (`bus_sel` = 2'b01) ORs a 1 into bit 0 of word 0x010 (init done) and into bit 0 of word 0x018 (controller active). All other bits of those words are kept, and word 0x000 stores the written value.
- R4: For an accepted write to offset 0x000 of the common window (`bus_sel` = 2'b00), the decoded values are as follows. `geo_row_bits` = `bus_wdata[7:4]` + 1, giving 1 to 16. `geo_bank_bits` = `bus_wdata[2]` + 2. `geo_page_bytes` = 1 << (`bus_wdata[11:8]` + 3), giving 8 to 262144.
- R5: `geo_valid` is high for exactly the one cycle after each accepted common-window write to offset 0x000. The geometry outputs keep their last decoded values at all other times.
- R6: A word index at or above the window's implemented register count reads as zero, and a write to it changes no word.
- R7: An access is accepted only when `bus_size` = 2'b10 (32-bit) and `bus_addr[1:0]` = 0. Any other access reads as zero, stores nothing and has no side effect.
- R8: `bus_sel` = 2'b11 selects no window. It reads as zero and writes have no effect. The codes 2'b00, 2'b01 and 2'b10 select the common, controller and PHY windows.
- R9: The windows are independent. Offset 0x000 of the PHY window and every word of the common window other than offset 0x000 are plain storage with no side effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 2 | Window select: 00 common, 01 controller, 10 PHY, 11 none |
| bus_addr | input | 12 | Byte address inside the window |
| bus_size | input | 2 | Access size code; 2'b10 is a 32-bit access |
| bus_we | input | 1 | Write enable |
| bus_wdata | input | 32 | Write data |
| rd_data | output | 32 | Registered read data, one cycle latency |
| geo_valid | output | 1 | One-cycle strobe for new geometry |
| geo_row_bits | output | 5 | Decoded row address width |
| geo_bank_bits | output | 2 | Decoded bank address width |
| geo_page_bytes | output | 19 | Decoded page size in bytes |

## Verification
Two things can happen in the same cycle: the registered read of a word, and a write to that same word or a flag update to it. The bench targets exactly this. It writes the PHY initialisation word and the status words back to back while their addresses are being read, and it also sends random traffic that is biased toward the low offsets. On every clock, a behavioural model that reads before it writes supplies the expected old value, and the flag bits are then checked through the next read.

// File: rtl/dsr_pkg.sv
package dsr_pkg;
  localparam int WORD_W     = 32;
  localparam int WIN_ADDR_W = 12;
  localparam int IDX_W      = WIN_ADDR_W - 2;
  localparam int ROW_W      = 5;
  localparam int BANK_W     = 2;
  localparam int PAGE_W     = 19;
  localparam int N_WIN      = 3;

  localparam logic [1:0] SIZE_WORD = 2'b10;

  typedef enum logic [1:0] {
    WIN_COMMON = 2'b00,
    WIN_CTRL   = 2'b01,
    WIN_PHY    = 2'b10,
    WIN_NONE   = 2'b11
  } win_e;

  // word indices inside the controller window
  localparam int CTRL_INIT_IDX   = 0;
  localparam int CTRL_PHYST_IDX  = 4;
  localparam int CTRL_ACTIVE_IDX = 6;

  typedef struct packed {
    logic [ROW_W-1:0]  row;
    logic [BANK_W-1:0] bank;
    logic [PAGE_W-1:0] page;
  } geom_t;
endpackage

// File: rtl/dsr_window.sv
module dsr_window #(
  parameter int N_REGS   = 64,
  parameter int IDX_W    = 10,
  parameter int WORD_W   = 32,
  parameter bit FLAG_EN  = 1'b0,
  parameter int FLAG_A   = 4,
  parameter int FLAG_B   = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  idx,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              flag_set,
  output logic [WORD_W-1:0] rd_word
);
  localparam int SLOT_W = (N_REGS > 1) ? $clog2(N_REGS) : 1;

  logic [WORD_W-1:0] mem [N_REGS];
  logic              hit;
  logic [SLOT_W-1:0] slot;

  assign hit  = ({1'b0, idx} < (IDX_W+1)'(N_REGS));
  assign slot = idx[SLOT_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N_REGS; i++) mem[i] <= '0;
    end else begin
      if (wr_en && hit) mem[slot] <= wr_data;
      if (FLAG_EN && flag_set) begin
        mem[FLAG_A][0] <= 1'b1;
        mem[FLAG_B][0] <= 1'b1;
      end
    end
  end

  assign rd_word = hit ? mem[slot] : '0;
endmodule

// File: rtl/dsr_geom_decode.sv
module dsr_geom_decode
  import dsr_pkg::*;
(
  input  logic [WORD_W-1:0] ctl_word,
  output geom_t             geom
);
  logic [4:0] page_shift;

  always_comb begin
    page_shift = {1'b0, ctl_word[11:8]} + 5'd3;
    geom.row   = {1'b0, ctl_word[7:4]} + ROW_W'(1);
    geom.bank  = {1'b0, ctl_word[2]} + BANK_W'(2);
    geom.page  = PAGE_W'(1) << page_shift;
  end
endmodule

// File: rtl/dram_reg_stub.sv
module dram_reg_stub
  import dsr_pkg::*;
#(
  parameter int COM_REGS = 64,
  parameter int CTL_REGS = 64,
  parameter int PHY_REGS = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        bus_sel,
  input  logic [11:0]       bus_addr,
  input  logic [1:0]        bus_size,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       rd_data,
  output logic              geo_valid,
  output logic [ROW_W-1:0]  geo_row_bits,
  output logic [BANK_W-1:0] geo_bank_bits,
  output logic [PAGE_W-1:0] geo_page_bytes
);
  logic              acc;
  logic [IDX_W-1:0]  idx;
  logic              idx_zero;
  logic              init_hit;
  logic              ctl_hit;
  logic [WORD_W-1:0] win_rd [N_WIN];
  logic [WORD_W-1:0] rd_next;
  geom_t             dec;

  assign acc      = (bus_size == SIZE_WORD) && (bus_addr[1:0] == 2'b00) &&
                    (bus_sel != WIN_NONE);
  assign idx      = bus_addr[WIN_ADDR_W-1:2];
  assign idx_zero = (idx == '0);
  assign init_hit = acc && bus_we && (bus_sel == WIN_CTRL) && idx_zero;
  assign ctl_hit  = acc && bus_we && (bus_sel == WIN_COMMON) && idx_zero;

  for (genvar g = 0; g < N_WIN; g++) begin : g_win
    localparam int CNT = (g == 0) ? COM_REGS : (g == 1) ? CTL_REGS : PHY_REGS;
    logic wr_g;
    assign wr_g = acc && bus_we && (bus_sel == 2'(g));
    dsr_window #(
      .N_REGS (CNT),
      .IDX_W  (IDX_W),
      .WORD_W (WORD_W),
      .FLAG_EN(g == 1),
      .FLAG_A (CTRL_PHYST_IDX),
      .FLAG_B (CTRL_ACTIVE_IDX)
    ) i_win (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (wr_g),
      .idx     (idx),
      .wr_data (bus_wdata),
      .flag_set(init_hit),
      .rd_word (win_rd[g])
    );
  end

  dsr_geom_decode i_dec (
    .ctl_word(bus_wdata),
    .geom    (dec)
  );

  always_comb begin
    rd_next = '0;
    if (acc) begin
      case (bus_sel)
        WIN_COMMON: rd_next = win_rd[0];
        WIN_CTRL:   rd_next = win_rd[1];
        WIN_PHY:    rd_next = win_rd[2];
        default:    rd_next = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data        <= '0;
      geo_valid      <= 1'b0;
      geo_row_bits   <= '0;
      geo_bank_bits  <= '0;
      geo_page_bytes <= '0;
    end else begin
      rd_data   <= rd_next;
      geo_valid <= ctl_hit;
      if (ctl_hit) begin
        geo_row_bits   <= dec.row;
        geo_bank_bits  <= dec.bank;
        geo_page_bytes <= dec.page;
      end
    end
  end
endmodule

// File: rtl/dsr_checker.sv
module dsr_checker
  import dsr_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic [1:0]        bus_sel,
  input logic [11:0]       bus_addr,
  input logic [1:0]        bus_size,
  input logic              bus_we,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       rd_data,
  input logic              geo_valid,
  input logic [ROW_W-1:0]  geo_row_bits,
  input logic [BANK_W-1:0] geo_bank_bits,
  input logic [PAGE_W-1:0] geo_page_bytes
);
  logic ctl_wr;
  assign ctl_wr = bus_we && bus_sel == 2'b00 && bus_size == 2'b10 && bus_addr == 12'h000;

  AST_GEO_STROBE: assert property (@(posedge clk) disable iff (rst)
    ctl_wr |=> geo_valid); // R5
  AST_GEO_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
    (!ctl_wr && !$past(rst)) |=> !geo_valid); // R5
  AST_ROW_DECODE: assert property (@(posedge clk) disable iff (rst)
    ctl_wr |=> geo_row_bits == {1'b0, $past(bus_wdata[7:4])} + 5'd1); // R4
  AST_PAGE_ONE_BIT: assert property (@(posedge clk) disable iff (rst)
    geo_valid |-> $countones(geo_page_bytes) == 1); // R4
  AST_GEO_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!ctl_wr && !$past(rst)) |=> $stable(geo_page_bytes) && $stable(geo_row_bits)); // R5
  AST_BAD_SIZE_ZERO: assert property (@(posedge clk) disable iff (rst)
    (bus_size != 2'b10) |=> rd_data == 32'h0); // R7
  AST_NO_WINDOW_ZERO: assert property (@(posedge clk) disable iff (rst)
    (bus_sel == 2'b11) |=> rd_data == 32'h0); // R8
endmodule

bind dram_reg_stub dsr_checker i_dsr_checker (.*);

// File: tb/test_dram_reg_stub.sv
module test_dram_reg_stub;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  bus_sel = 2'b00;
  logic [11:0] bus_addr = '0;
  logic [1:0]  bus_size = 2'b10;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] rd_data;
  logic        geo_valid;
  logic [4:0]  geo_row_bits;
  logic [1:0]  geo_bank_bits;
  logic [18:0] geo_page_bytes;

  int checks = 0;
  int errors = 0;
  logic [31:0] model [3][64];
  int e_row = 0, e_bank = 0, e_page = 0;

  always #5 clk = ~clk;

  dram_reg_stub i_dram_reg_stub (.*);

  task automatic chk(input string tag, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  // drive at a falling edge, compare at the next falling edge
  task automatic step(input logic [1:0] s, input logic [11:0] a, input logic [1:0] z,
                      input logic w, input logic [31:0] d, input string tag);
    logic acc;
    int ix;
    logic [31:0] e_rd;
    logic e_gv;
    bus_sel = s; bus_addr = a; bus_size = z; bus_we = w; bus_wdata = d;
    acc  = (z == 2'b10) && (a[1:0] == 2'b00) && (s != 2'b11);
    ix   = int'(a[11:2]);
    e_rd = (acc && ix < 64) ? model[s][ix] : 32'h0;
    if (acc && w && ix < 64) model[s][ix] = d;
    if (acc && w && s == 2'b01 && ix == 0) begin
      model[1][4][0] = 1'b1;
      model[1][6][0] = 1'b1;
    end
    e_gv = acc && w && s == 2'b00 && ix == 0;
    if (e_gv) begin
      e_row  = int'(d[7:4]) + 1;
      e_bank = int'(d[2]) + 2;
      e_page = 1 << (int'(d[11:8]) + 3);
    end
    @(negedge clk);
    chk(tag, "rd_data", rd_data, e_rd);
    chk(tag, "geo_valid", geo_valid, e_gv);
    chk(tag, "geo_row_bits", geo_row_bits, e_row);
    chk(tag, "geo_bank_bits", geo_bank_bits, e_bank);
    chk(tag, "geo_page_bytes", geo_page_bytes, e_page);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int w = 0; w < 3; w++)
      for (int i = 0; i < 64; i++) model[w][i] = 32'h0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: cleared state
    chk("R1", "geo_valid", geo_valid, 0);
    chk("R1", "rd_data", rd_data, 0);
    for (int w = 0; w < 3; w++) begin
      step(2'(w), 12'h000, 2'b10, 1'b0, 0, "R1");
      step(2'(w), 12'h0FC, 2'b10, 1'b0, 0, "R1");
    end
    // R2: storage, read returns the pre-write value
    step(2'b00, 12'h004, 2'b10, 1'b1, 32'hA5A5_5A5A, "R2");
    step(2'b00, 12'h004, 2'b10, 1'b1, 32'h1357_9BDF, "R2");
    step(2'b00, 12'h004, 2'b10, 1'b0, 0, "R2");
    step(2'b10, 12'h0FC, 2'b10, 1'b1, 32'hFFFF_FFFF, "R2");
    step(2'b10, 12'h0FC, 2'b10, 1'b0, 0, "R2");
    // R3: init write sets flags with OR, stores its own value
    step(2'b01, 12'h010, 2'b10, 1'b1, 32'h0000_00F0, "R3");
    step(2'b01, 12'h000, 2'b10, 1'b1, 32'h0000_1234, "R3");
    step(2'b01, 12'h010, 2'b10, 1'b0, 0, "R3");
    step(2'b01, 12'h018, 2'b10, 1'b0, 0, "R3");
    step(2'b01, 12'h000, 2'b10, 1'b0, 0, "R3");
    step(2'b01, 12'h018, 2'b10, 1'b1, 32'h8000_0000, "R3");
    step(2'b01, 12'h000, 2'b10, 1'b1, 32'h0, "R3");
    step(2'b01, 12'h018, 2'b10, 1'b0, 0, "R3");
    // R4 / R5: geometry corners and hold
    step(2'b00, 12'h000, 2'b10, 1'b1, 32'h0000_0000, "R4");
    step(2'b00, 12'h000, 2'b10, 1'b1, 32'h0000_0FF4, "R4");
    step(2'b00, 12'h000, 2'b10, 1'b1, 32'hFFFF_F0FB, "R4");
    step(2'b00, 12'h008, 2'b10, 1'b1, 32'h0000_0A30, "R5");
    step(2'b00, 12'h000, 2'b10, 1'b0, 0, "R5");
    step(2'b00, 12'h000, 2'b10, 1'b1, 32'h0000_0A34, "R5");
    step(2'b00, 12'h000, 2'b10, 1'b0, 0, "R5");
    // R6: index beyond the implemented count
    step(2'b01, 12'h100, 2'b10, 1'b1, 32'hDEAD_BEEF, "R6");
    step(2'b01, 12'h100, 2'b10, 1'b0, 0, "R6");
    step(2'b01, 12'h000, 2'b10, 1'b0, 0, "R6");
    step(2'b00, 12'hFFC, 2'b10, 1'b1, 32'h1111_1111, "R6");
    step(2'b00, 12'h000, 2'b10, 1'b0, 0, "R6");
    // R7: non-word size and misaligned address
    step(2'b00, 12'h000, 2'b01, 1'b1, 32'h0000_0F00, "R7");
    step(2'b01, 12'h001, 2'b10, 1'b1, 32'h5555_5555, "R7");
    step(2'b01, 12'h000, 2'b00, 1'b0, 0, "R7");
    step(2'b00, 12'h004, 2'b10, 1'b0, 0, "R7");
    // R8: no window selected
    step(2'b11, 12'h000, 2'b10, 1'b1, 32'h0000_0770, "R8");
    step(2'b11, 12'h004, 2'b10, 1'b0, 0, "R8");
    // R9: PHY offset 0 and common words have no side effect
    rst = 1'b1;
    for (int w = 0; w < 3; w++)
      for (int i = 0; i < 64; i++) model[w][i] = 32'h0;
    e_row = 0; e_bank = 0; e_page = 0;
    @(negedge clk);
    rst = 1'b0;
    step(2'b10, 12'h000, 2'b10, 1'b1, 32'h0000_0001, "R9");
    step(2'b00, 12'h010, 2'b10, 1'b1, 32'h0000_0002, "R9");
    step(2'b01, 12'h010, 2'b10, 1'b0, 0, "R9");
    step(2'b01, 12'h018, 2'b10, 1'b0, 0, "R9");
    step(2'b10, 12'h010, 2'b10, 1'b0, 0, "R9");
    // mixed traffic on low offsets, all requirements
    for (int n = 0; n < 800; n++) begin
      logic [1:0]  s;
      logic [11:0] a;
      logic [1:0]  z;
      s = 2'($urandom_range(0, 3));
      a = ($urandom_range(0, 7) == 0) ? 12'($urandom) : 12'($urandom_range(0, 9) << 2);
      z = ($urandom_range(0, 9) == 0) ? 2'($urandom) : 2'b10;
      step(s, a, z, 1'($urandom), $urandom, "R2");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule